// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block is a synthesizable behavioural model of a single-port synchronous SRAM. Each word is 36 bits wide and is split into four 9-bit lanes. Lane i holds bits 9i+8 down to 9i, which is eight data bits and one parity bit. Address, chip enables, write controls and write data are captured on the rising clock edge. Read data passes through an output register, so a word read at one edge reaches the pins after the following edge.

An access starts from one of two active-low strobes. The processor strobe counts only while the first chip enable is low, and its first cycle is always a read. The controller strobe always samples the three chip enables and may write in its first cycle. Once an access is open, a step input advances a two-bit burst counter. The counter wraps within the four-word block of the start address, which gives one word per clock after the first.

A small control state machine has three states:
- `ST_IDLE`: no access is open.
- `ST_ACTIVE`: a burst is open.
- `ST_SLEEP`: sleep is asserted.

Its transitions are:
- *start*: a qualified strobe with all chip enables true moves IDLE or ACTIVE to ACTIVE.
- *deselect*: a qualified strobe with any chip enable false moves IDLE or ACTIVE to IDLE.
- *continue*: with no strobe, ACTIVE stays ACTIVE.
- *doze*: sleep high moves IDLE or ACTIVE to SLEEP.
- *wake*: sleep low moves SLEEP to IDLE.

A registered chip-on flag gates the output stage. The output enable and sleep gate the outputs asynchronously. High impedance is modelled as `rdata_valid` low with `rdata` at zero.

Top module: `pbsram_core`

## Requirements
- R1: After reset, `rdata_valid` is 0 and `rdata` is 0.
- R2: A read registered at clock edge N shows on `rdata` with `rdata_valid` high after edge N+1, and not after edge N.
- R3: A controller strobe start with chip selected and write controls active stores `wdata` at `addr` on that edge.
- R4: While ACTIVE with no strobe, `burst_step_n` low at an edge moves the access to the next address, computed as the low two address bits plus one modulo 4 with the upper bits kept. `burst_step_n` high keeps the same address.
- R5: The first cycle of a processor strobe start is a read even when write controls are active. Write controls are honoured on the cycles that follow.
- R6: `wr_all_n` low writes all four lanes, whatever `wr_lane_en_n` and `wr_lane_sel_n` hold.
- R7: With `wr_all_n` high and `wr_lane_en_n` low, only the lanes whose `wr_lane_sel_n` bit i is 0 are written (bit i covers `wdata[9i+8:9i]`). Other lanes keep their contents. With both high, nothing is written.
- R8: A qualified strobe while not fully selected (selection needs `en_a_n`=0, `en_b`=1, `en_c_n`=0) starts no access and writes nothing. The output is invalid after the next edge.
- R9: With `en_a_n` high, the processor strobe is ignored, so a running burst continues unchanged.
- R10: `out_en_n` high drives `rdata_valid` low and `rdata` to zero at once, without a clock edge. The registered word returns when `out_en_n` goes low.
- R11: Sleep high blocks writes and reads and forces the outputs invalid, and array contents are kept. After sleep ends, a new strobe is needed before any access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control and output registers |
| addr | input | ADDR_W | Word address sampled on a start |
| strobe_cpu_n | input | 1 | Processor strobe, active low, counted only while `en_a_n` is low |
| strobe_ctl_n | input | 1 | Controller strobe, active low |
| burst_step_n | input | 1 | Active low: advance the burst counter |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | Active low: write all lanes |
| wr_lane_en_n | input | 1 | Active low: enable per-lane writes |
| wr_lane_sel_n | input | LANES | Active-low lane selects |
| wdata | input | LANES*LANE_W | Write word |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | LANES*LANE_W | Read word, zero while invalid |
| rdata_valid | output | 1 | High when the output would be driven |

## Verification
A read registered at a strobe edge is due two edges after its inputs were driven. A burst word is due one edge after the step that selected it. The bench drives inputs at the falling edge and samples after that many rising edges, and it also checks that nothing valid appears one edge early. Writes have no direct output, so each write is followed by a full read that is checked against a bench shadow array. Output-enable gating is checked within the same cycle, a nanosecond after the pin changes. Sleep and deselect are checked at the edge where the output would otherwise have become valid.

// File: rtl/pbsram_pkg.sv
`timescale 1ns/1ps
package pbsram_pkg;

    localparam int BURST_W = 2;
    localparam logic [BURST_W-1:0] CNT_STEP = BURST_W'(1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_SLEEP  = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/pbsram_ctrl.sv
`timescale 1ns/1ps
module pbsram_ctrl
    import pbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              burst_step_n,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              wr_all_n,
    input  logic              wr_lane_en_n,
    input  logic [LANES-1:0]  wr_lane_sel_n,
    input  logic              sleep,
    output logic [LANES-1:0]  lane_we,
    output logic [ADDR_W-1:0] cell_addr,
    output logic [ADDR_W-1:0] rd_addr_q,
    output logic              rd_pend_q,
    output logic              chip_on_q,
    output ctl_state_e        state_q
);

    ctl_state_e         state_d;
    logic [ADDR_W-1:0]  base_q, base_d;
    logic [BURST_W-1:0] cnt_q, cnt_d;
    logic               chip_d;
    logic               selected, cpu_go, ctl_go;
    logic               do_acc, wr_ok, rd_now;
    logic [LANES-1:0]   lanes_req;

    // Next-state and access decode
    always_comb begin
        selected  = !en_a_n && en_b && !en_c_n;
        cpu_go    = !strobe_cpu_n && !en_a_n;
        ctl_go    = !strobe_ctl_n && !cpu_go;
        lanes_req = !wr_all_n ? {LANES{1'b1}}
                  : (!wr_lane_en_n ? ~wr_lane_sel_n : {LANES{1'b0}});
        state_d   = state_q;
        base_d    = base_q;
        cnt_d     = cnt_q;
        chip_d    = chip_on_q;
        cell_addr = base_q;
        do_acc    = 1'b0;
        wr_ok     = 1'b0;
        unique case (state_q)
            ST_SLEEP: begin
                chip_d = 1'b0;
                if (!sleep) state_d = ST_IDLE;            // wake
            end
            ST_IDLE, ST_ACTIVE: begin
                if (sleep) begin                          // doze
                    state_d = ST_SLEEP;
                    chip_d  = 1'b0;
                end else if (cpu_go || ctl_go) begin
                    chip_d = selected;
                    if (selected) begin                   // start
                        state_d   = ST_ACTIVE;
                        base_d    = addr;
                        cnt_d     = '0;
                        cell_addr = addr;
                        do_acc    = 1'b1;
                        wr_ok     = ctl_go;
                    end else begin                        // deselect
                        state_d = ST_IDLE;
                    end
                end else if (state_q == ST_ACTIVE) begin  // continue
                    if (!burst_step_n) cnt_d = cnt_q + CNT_STEP;
                    cell_addr = {base_q[ADDR_W-1:BURST_W], base_q[BURST_W-1:0] + cnt_d};
                    do_acc    = 1'b1;
                    wr_ok     = 1'b1;
                end
            end
        endcase
        lane_we = (do_acc && wr_ok) ? lanes_req : {LANES{1'b0}};
        rd_now  = do_acc && (lane_we == {LANES{1'b0}});
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            base_q    <= '0;
            cnt_q     <= '0;
            chip_on_q <= 1'b0;
            rd_addr_q <= '0;
            rd_pend_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            base_q    <= base_d;
            cnt_q     <= cnt_d;
            chip_on_q <= chip_d;
            rd_addr_q <= cell_addr;
            rd_pend_q <= rd_now;
        end
    end

    // R4: a step moves to the next word of the block
    a_r4_burst_next: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && strobe_cpu_n && strobe_ctl_n && !burst_step_n && !sleep)
        |=> rd_addr_q[BURST_W-1:0] == $past(rd_addr_q[BURST_W-1:0]) + CNT_STEP);

    // R4: no step holds the address
    a_r4_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && strobe_cpu_n && strobe_ctl_n && burst_step_n && !sleep)
        |=> rd_addr_q == $past(rd_addr_q));

endmodule

// File: rtl/pbsram_array.sv
`timescale 1ns/1ps
module pbsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rword
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rword[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/pbsram_outreg.sv
`timescale 1ns/1ps
module pbsram_outreg #(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_pend,
    input  logic              chip_on,
    input  logic              sleep,
    input  logic              out_en_n,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_valid
);

    logic [WORD_W-1:0] hold_q;
    logic              vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= rd_pend && chip_on && !sleep;
            if (rd_pend) hold_q <= word_in;
        end
    end

    always_comb begin
        rdata_valid = vld_q && !out_en_n && !sleep;
        rdata       = rdata_valid ? hold_q : '0;
    end

    // R2: valid output only follows a registered read
    a_r2_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> $past(rd_pend && chip_on));

endmodule

// File: rtl/pbsram_core.sv
`timescale 1ns/1ps
module pbsram_core
    import pbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    burst_step_n,
    input  logic                    en_a_n,
    input  logic                    en_b,
    input  logic                    en_c_n,
    input  logic                    wr_all_n,
    input  logic                    wr_lane_en_n,
    input  logic [LANES-1:0]        wr_lane_sel_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    out_en_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_valid
);

    localparam int WORD_W = LANES * LANE_W;

    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] cell_addr, rd_addr_q;
    logic              rd_pend_q, chip_on_q;
    ctl_state_e        state_q;
    logic [WORD_W-1:0] rword;

    pbsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
        .burst_step_n(burst_step_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .wr_lane_sel_n(wr_lane_sel_n),
        .sleep(sleep), .lane_we(lane_we), .cell_addr(cell_addr),
        .rd_addr_q(rd_addr_q), .rd_pend_q(rd_pend_q), .chip_on_q(chip_on_q),
        .state_q(state_q)
    );

    pbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .lane_we(lane_we), .waddr(cell_addr), .wdata(wdata),
        .raddr(rd_addr_q), .rword(rword)
    );

    pbsram_outreg #(.WORD_W(WORD_W)) u_out (
        .clk(clk), .rst_n(rst_n), .rd_pend(rd_pend_q), .chip_on(chip_on_q),
        .sleep(sleep), .out_en_n(out_en_n), .word_in(rword),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    logic start_try, fully_sel;
    assign start_try = (!strobe_cpu_n && !en_a_n) || !strobe_ctl_n;
    assign fully_sel = !en_a_n && en_b && !en_c_n;

    // R5: processor-strobe start never writes
    a_r5_cpu_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu_n && !en_a_n && !sleep && state_q != ST_SLEEP) |-> lane_we == '0);

    // R6: global write covers every lane
    a_r6_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0 && !wr_all_n) |-> lane_we == {LANES{1'b1}});

    // R8: deselecting start leaves the output invalid
    a_r8_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (start_try && !fully_sel && !sleep && state_q != ST_SLEEP)
        |-> (lane_we == '0) ##2 !rdata_valid);

    // R11: sleep blocks writes and the next read
    a_r11_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (lane_we == '0) ##1 !rd_pend_q);

endmodule

// File: tb/tb_pbsram_core.sv
`timescale 1ns/1ps
module tb_pbsram_core;

    localparam int AW = 6;
    localparam int W  = 36;

    logic          clk, rst_n;
    logic [AW-1:0] addr;
    logic          strobe_cpu_n, strobe_ctl_n, burst_step_n;
    logic          en_a_n, en_b, en_c_n;
    logic          wr_all_n, wr_lane_en_n;
    logic [3:0]    wr_lane_sel_n;
    logic [W-1:0]  wdata, rdata;
    logic          out_en_n, sleep, rdata_valid;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] em [64];

    pbsram_core dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
        .burst_step_n(burst_step_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .wr_lane_sel_n(wr_lane_sel_n),
        .wdata(wdata), .out_en_n(out_en_n), .sleep(sleep),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [W-1:0] pat(input int a, input int s);
        return (36'(a) * 36'h0_1F3D_5B79) ^ (36'(s) * 36'h0_9E37_79B9) ^ 36'h5_A5A5_A5A5;
    endfunction

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h want %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic quiet();
        strobe_cpu_n = 1; strobe_ctl_n = 1; burst_step_n = 1;
        wr_all_n = 1; wr_lane_en_n = 1; wr_lane_sel_n = 4'hF;
        en_a_n = 0; en_b = 1; en_c_n = 0;
    endtask

    task automatic close();
        quiet(); strobe_ctl_n = 0; en_b = 0;
        cyc(); quiet(); cyc(); cyc();
        chk(W'(rdata_valid), '0, "R8 idle after deselect");
    endtask

    task automatic wr_ctl(input int a, input logic [W-1:0] d, input logic all_n,
                          input logic len_n, input logic [3:0] sel_n);
        quiet(); strobe_ctl_n = 0; addr = AW'(a); wdata = d;
        wr_all_n = all_n; wr_lane_en_n = len_n; wr_lane_sel_n = sel_n;
        cyc(); quiet(); close();
    endtask

    task automatic rd_check(input int a, input string tag);
        quiet(); strobe_ctl_n = 0; addr = AW'(a);
        cyc();
        quiet();
        chk(W'(rdata_valid), '0, "R2 not one edge early");
        cyc();
        chk(W'(rdata_valid), W'(1), tag);
        chk(rdata, em[a], tag);
        close();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got hang want finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        quiet(); addr = '0; wdata = '0; out_en_n = 0; sleep = 0; rst_n = 0;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk(W'(rdata_valid), '0, "R1 valid after reset");
        chk(rdata, '0, "R1 data after reset");

        // R3: fill every address by controller-strobe global writes
        for (int a = 0; a < 64; a++) begin
            wr_ctl(a, pat(a, 1), 1'b0, 1'b1, 4'hF);
            em[a] = pat(a, 1);
        end

        // R2: back-to-back reads, one word per clock, one extra edge of latency
        for (int a = 0; a <= 64; a++) begin
            quiet();
            if (a < 64) begin strobe_ctl_n = 0; addr = AW'(a); end
            cyc();
            if (a > 0) begin
                chk(W'(rdata_valid), W'(1), "R2 pipelined valid");
                chk(rdata, em[a-1], "R2 R3 pipelined data");
            end
        end
        close();

        // R6: global write overrides the lane controls
        for (int a = 0; a < 4; a++) begin
            wr_ctl(a, pat(a, 6), 1'b0, 1'b0, 4'(a));
            em[a] = pat(a, 6);
            rd_check(a, "R6 all lanes written");
        end

        // R7: every lane-select pattern on one address
        for (int s = 0; s < 16; s++) begin
            logic [W-1:0] d;
            d = pat(s, 7);
            wr_ctl(10, d, 1'b1, 1'b0, 4'(s));
            for (int l = 0; l < 4; l++)
                if (!s[l]) em[10][l*9 +: 9] = d[l*9 +: 9];
            rd_check(10, "R7 lane merge");
        end
        wr_ctl(10, ~em[10], 1'b1, 1'b1, 4'h0);
        rd_check(10, "R7 no write without lane enable");

        // R5: processor start reads first, then writes on the next cycle
        quiet(); strobe_cpu_n = 0; addr = 20; wr_all_n = 0; wdata = pat(99, 5);
        cyc();
        quiet(); wr_all_n = 0; wdata = pat(98, 5);
        cyc();
        chk(rdata, em[20], "R5 first cycle is a read");
        em[20] = pat(98, 5);
        quiet(); close();
        rd_check(20, "R5 later cycle writes");

        // R4: burst from each offset in a block, with wrap and hold
        for (int off = 0; off < 4; off++) begin
            quiet(); strobe_cpu_n = 0; addr = AW'(32 + off);
            cyc();
            quiet(); burst_step_n = 0;
            cyc(); chk(rdata, em[32 + off], "R4 burst word 0");
            cyc(); chk(rdata, em[32 + ((off + 1) % 4)], "R4 burst word 1");
            cyc(); chk(rdata, em[32 + ((off + 2) % 4)], "R4 burst word 2");
            burst_step_n = 1;
            cyc(); chk(rdata, em[32 + ((off + 3) % 4)], "R4 burst word 3");
            cyc(); chk(rdata, em[32 + ((off + 3) % 4)], "R4 hold without step");
            close();
        end

        // R9: processor strobe ignored while en_a_n is high
        quiet(); strobe_cpu_n = 0; addr = 36;
        cyc();
        quiet(); strobe_cpu_n = 0; en_a_n = 1; addr = 50; burst_step_n = 0;
        cyc(); chk(rdata, em[36], "R9 burst start");
        quiet(); burst_step_n = 0;
        cyc(); chk(rdata, em[37], "R9 burst continues");
        cyc(); chk(rdata, em[38], "R9 burst continues");
        close();

        // R8: all chip-enable combinations
        for (int c = 0; c < 8; c++) begin
            quiet(); strobe_ctl_n = 0; addr = 40;
            {en_a_n, en_b, en_c_n} = 3'(c);
            cyc();
            quiet();
            cyc();
            chk(W'(rdata_valid), (c == 2) ? W'(1) : W'(0), "R8 selection decode");
            close();
        end
        quiet(); strobe_ctl_n = 0; addr = 41; wr_all_n = 0; wdata = ~em[41]; en_c_n = 1;
        cyc(); close();
        rd_check(41, "R8 deselected write ignored");

        // R10: asynchronous output enable
        quiet(); strobe_ctl_n = 0; addr = 5;
        cyc(); quiet(); cyc();
        out_en_n = 1; #1;
        chk(W'(rdata_valid), '0, "R10 valid off");
        chk(rdata, '0, "R10 data off");
        out_en_n = 0; #1;
        chk(rdata, em[5], "R10 data back");
        close();

        // R11: write under sleep is blocked
        quiet(); sleep = 1; strobe_ctl_n = 0; addr = 7; wr_all_n = 0; wdata = ~em[7];
        cyc(); quiet(); cyc();
        chk(W'(rdata_valid), '0, "R11 invalid in sleep");
        sleep = 0; cyc();
        rd_check(7, "R11 contents kept");

        // R11: read cut by sleep, and no restart without a strobe
        quiet(); strobe_ctl_n = 0; addr = 8;
        cyc(); quiet(); sleep = 1;
        cyc(); chk(W'(rdata_valid), '0, "R11 read blocked");
        cyc(); sleep = 0; cyc();
        burst_step_n = 0;
        cyc(); cyc();
        chk(W'(rdata_valid), '0, "R11 no access after wake");
        quiet(); cyc();
        rd_check(8, "R11 read after wake");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule